// File: doc/BRIEF.md
# Phase-Accumulator PWM with Staged Configuration

This block produces one pulse-width-modulated output from a single 32-bit control word. The output rate comes from a phase accumulator that adds a programmable step on every clock. One output cycle ends, and the next begins, each time the accumulator carries out of its top bit. An 8-bit threshold sets the duty. The threshold is encoded inverted: a larger value gives a shorter high time. The output is high whenever the top eight accumulator bits are at or above the live threshold.

Step and threshold are written into a shadow copy. The generator uses them only after software commits them with a request flag. That flag stays set until the generator adopts the shadow values at the next output-cycle boundary, and while it is set the register refuses every write. The enable bit takes effect on the clock after it is written and is not staged. The usual software sequence writes the new fields first, then writes the same word again with the request flag set, then polls until the flag reads back clear.

Top module: `acc_pwm`

## Requirements
- R1: After reset the read word is all zeros and `pwm_o` is low.
- R2: A write with bit 30 clear stores bit 31 (enable), bits [8+STEP_W-1:8] (step) and bits [7:0] (threshold), which are visible on the read word at once. The step and threshold the generator is running with stay unchanged.
- R3: A write with bit 30 set stores the fields and sets the request flag, which reads back on bit 30. Any write that arrives while the flag is set is ignored, and the read word stays unchanged.
- R4: While the generator runs, a pending request is committed on the clock where the accumulator carries out. The live step and threshold load from the shadow copy on that clock and the flag clears.
- R5: While the generator is idle (enable clear, or a live step of zero), a pending request commits on the next clock.
- R6: While running, the accumulator wraps on every clock where accumulator plus live step reaches 2^STEP_W. With a step that divides 2^STEP_W, the output period is 2^STEP_W / step clocks.
- R7: While running, `pwm_o` is high exactly when the top eight accumulator bits are greater than or equal to the live threshold. With STEP_W=10 and step 4, the output is high for 256 − threshold clocks of every 256.
- R8: With enable clear, the accumulator is held at zero and `pwm_o` is low. After re-enabling, the phase restarts from zero.
- R9: A live threshold of zero with a nonzero step keeps `pwm_o` high continuously while enabled.
- R10: The read word carries enable on bit 31, the flag on bit 30, the shadow step on bits [8+STEP_W-1:8] and the shadow threshold on bits [7:0]. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Control word to write |
| rdata_o | output | 32 | Current control word |
| pwm_o | output | 1 | PWM output |

## Verification
A live step or threshold that is wrong shows up on `pwm_o` within one output period, as a wrong period or a wrong high count. The bench measures both over whole periods after each commit. A commit on the wrong clock moves the phase. The bench therefore counts the clocks from the flag clearing to the next rising edge of the output, and an early or late load changes that count at once. A lock-out that fails is seen on the very next read, because an ignored write must leave the read word unchanged. A flag that never clears shows up as a poll that runs out.

// File: rtl/acc_pwm_pkg.sv
package acc_pwm_pkg;
  localparam int EnBit   = 31;
  localparam int UpdBit  = 30;
  localparam int StepLsb = 8;
  localparam int ThrW    = 8;
  typedef logic [ThrW-1:0] thr_t;
endpackage

// File: rtl/acc_pwm_ctrl.sv
module acc_pwm_ctrl
  import acc_pwm_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              commit_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [STEP_W-1:0] step_o,
  output thr_t              thr_o,
  output logic [31:0]       rdata_o
);
  logic              en_q, upd_q;
  logic [STEP_W-1:0] step_q;
  thr_t              thr_q;
  logic              accept;
  logic              unused_wr;

  assign unused_wr = ^wdata_i;
  // writes are locked out while a request is pending
  assign accept = wr_en_i && !upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      step_q <= '0;
      thr_q  <= '0;
    end else if (accept) begin
      en_q   <= wdata_i[EnBit];
      upd_q  <= wdata_i[UpdBit];
      step_q <= wdata_i[StepLsb +: STEP_W];
      thr_q  <= wdata_i[ThrW-1:0];
    end else if (commit_i) begin
      upd_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                    = '0;
    rdata_o[EnBit]             = en_q;
    rdata_o[UpdBit]            = upd_q;
    rdata_o[StepLsb +: STEP_W] = step_q;
    rdata_o[ThrW-1:0]          = thr_q;
  end

  assign en_o   = en_q;
  assign upd_o  = upd_q;
  assign step_o = step_q;
  assign thr_o  = thr_q;

  a_r3_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && wr_en_i |=> $stable(step_q) && $stable(thr_q) && $stable(en_q));

  a_r4_upd_fall_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_q) |-> $past(commit_i));
endmodule

// File: rtl/acc_pwm_phase.sv
module acc_pwm_phase
  import acc_pwm_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              upd_i,
  input  logic [STEP_W-1:0] step_sh_i,
  input  thr_t              thr_sh_i,
  output logic              commit_o,
  output logic              run_o,
  output thr_t              phase_o,
  output thr_t              thr_o
);
  localparam int SumW = STEP_W + 1;

  logic [STEP_W-1:0] acc_q, step_q;
  thr_t              thr_q;
  logic [SumW-1:0]   sum;
  logic              run, wrap;

  assign run      = en_i && (step_q != '0);
  assign sum      = {1'b0, acc_q} + {1'b0, step_q};
  assign wrap     = run && sum[STEP_W];
  // idle generator has no cycle boundary to wait for
  assign commit_o = upd_i && (!run || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else acc_q <= sum[STEP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      thr_q  <= '0;
    end else if (commit_o) begin
      step_q <= step_sh_i;
      thr_q  <= thr_sh_i;
    end
  end

  assign run_o   = run;
  assign phase_o = acc_q[STEP_W-1 -: ThrW];
  assign thr_o   = thr_q;

  a_r8_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);

  a_r6_wrap_residue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> acc_q < $past(step_q));
endmodule

// File: rtl/acc_pwm_cmp.sv
module acc_pwm_cmp
  import acc_pwm_pkg::*;
(
  input  logic run_i,
  input  thr_t phase_i,
  input  thr_t thr_i,
  output logic pwm_o
);
  assign pwm_o = run_i && (phase_i >= thr_i);
endmodule

// File: rtl/acc_pwm.sv
module acc_pwm
  import acc_pwm_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pwm_o
);
  logic              en, upd, commit, run;
  logic [STEP_W-1:0] step_sh;
  thr_t              thr_sh, thr_live, phase;

  acc_pwm_ctrl #(.STEP_W(STEP_W)) i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i,
    .commit_i(commit), .en_o(en), .upd_o(upd),
    .step_o(step_sh), .thr_o(thr_sh), .rdata_o
  );

  acc_pwm_phase #(.STEP_W(STEP_W)) i_phase (
    .clk_i, .rst_ni, .en_i(en), .upd_i(upd),
    .step_sh_i(step_sh), .thr_sh_i(thr_sh),
    .commit_o(commit), .run_o(run), .phase_o(phase), .thr_o(thr_live)
  );

  acc_pwm_cmp i_cmp (
    .run_i(run), .phase_i(phase), .thr_i(thr_live), .pwm_o
  );

  a_r5_idle_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[UpdBit] && !rdata_o[EnBit] |=> !rdata_o[UpdBit]);

  a_r8_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[EnBit] |-> !pwm_o);
endmodule

// File: tb/test_acc_pwm.sv
module test_acc_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  acc_pwm #(.STEP_W(10)) i_acc_pwm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_clear(output int n);
    n = 0;
    while (rdata[30] && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_high(input int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && pwm) break;
      prev = pwm;
    end
  endtask

  task automatic period(output int p);
    logic prev;
    wait_rise();
    p = 0;
    prev = pwm;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      p++;
      if (!prev && pwm) break;
      prev = pwm;
    end
  endtask

  task automatic t_reset();
    chk("R1 read word", rdata, 32'h0);
    chk("R1 pwm", {31'b0, pwm}, 32'h0);
  endtask

  task automatic t_idle_commit();
    wr(32'h7FFC_0440);
    chk("R10 R3 read word pending", rdata, 32'h4000_0440);
    @(negedge clk);
    chk("R5 idle commit next clock", rdata, 32'h0000_0440);
    chk("R8 pwm low while off", {31'b0, pwm}, 32'h0);
  endtask

  task automatic t_run();
    int h, p;
    wr(32'h8000_0440);
    chk("R2 enable readback", rdata, 32'h8000_0440);
    count_high(256, h);
    chk("R7 high count thr 64", h, 256 - 64);
    period(p);
    chk("R6 period step 4", p, 256);
  endtask

  task automatic t_staged();
    int h, n, p;
    wr(32'h8000_0864);
    chk("R2 shadow readback", rdata, 32'h8000_0864);
    count_high(256, h);
    chk("R2 live unchanged", h, 192);
    wait_rise();
    wr(32'hC000_0864);
    chk("R3 flag set", rdata, 32'hC000_0864);
    wr(32'hC000_0200);
    chk("R3 write ignored while pending", rdata, 32'hC000_0864);
    wait_clear(n);
    chk("R4 flag cleared", rdata, 32'h8000_0864);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (pwm) break;
      @(negedge clk);
      n++;
    end
    chk("R4 commit at cycle start", n, 50);
    period(p);
    chk("R6 period step 8", p, 128);
    count_high(128, h);
    chk("R7 high count step 8 thr 100", h, 78);
  endtask

  task automatic t_extremes();
    int h, n;
    wr(32'h8000_0400);
    wr(32'hC000_0400);
    wait_clear(n);
    @(negedge clk);
    count_high(300, h);
    chk("R9 thr zero always high", h, 300);
    wr(32'h8000_04FF);
    wr(32'hC000_04FF);
    wait_clear(n);
    count_high(256, h);
    chk("R7 thr 255 one clock", h, 1);
  endtask

  task automatic t_disable();
    int h, n;
    wr(32'h0000_04FF);
    chk("R8 disable readback", rdata, 32'h0000_04FF);
    count_high(50, h);
    chk("R8 low while disabled", h, 0);
    wr(32'h8000_04FF);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (pwm) break;
      @(negedge clk);
      n++;
    end
    chk("R8 phase restarts at zero", n, 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_commit();
    t_run();
    t_staged();
    t_extremes();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule